// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits between a CPU's physical address output and an internal interconnect. Software programs up to eight address windows through a small 32-bit register port. Each window names a 64 KB-aligned start address, a size given as a count of 64 KB pages, an interconnect target ID and an attribute byte. On every CPU lookup, the decoder compares the address against all enabled windows in parallel. One clock later it reports which target and attribute the access goes to, or it flags that no window claimed it.

The two lowest-numbered windows can also translate. For a hit in one of them, the address bits above the window's span are replaced with a programmed remap base, so a CPU region can be steered to a different address on the target. Hits in the other windows, and misses, return the address unchanged. Register reads are combinational. Register writes take effect at the clock edge on which they are presented.

Top module: `cpu_win_decoder`

## Requirements
- R1: After reset, every register reads zero and all decode outputs are low or zero.
- R2: The register port takes a word index. Window n uses words 4n+0 to 4n+3, which are byte offsets 16n+0x0, 0x4, 0x8 and 0xC. The control word (word 4n+0) reads back exactly as written. The base word (word 4n+1) keeps bits 31:16 and reads its low 16 bits as zero.
- R3: Windows 0 and 1 have a remap-low word (4n+2) and a remap-high word (4n+3). Remap-low keeps bits 31:16 and reads its low 16 bits as zero. Remap-high keeps and returns all 32 bits.
- R4: For windows 2 to 7, the remap words read as zero. Writes to those words change neither the readback nor any decode result.
- R5: Control word fields are: bits 31:16 = size in 64 KB pages minus one, bits 15:8 = attribute, bit 5 = enable, bits 3:0 = target. An enabled window hits when the address equals the base in every bit that the size field does not cover. For a base aligned to its size, that is the range from the base to base + (size+1)*64 KB - 1. A hit drives dec_hit=1 with that window's target and attribute.
- R6: A window whose enable bit is 0 never hits, whatever its other fields hold. Writing zero to a control word disables that window.
- R7: When several enabled windows contain the address, the lowest-numbered window supplies target, attribute and address.
- R8: A valid lookup that no window claims gives dec_miss=1, dec_hit=0, target 0, attribute 0, and dec_addr equal to the input address.
- R9: On a hit in window 0 or 1, dec_addr keeps the address bits inside the window span (the low 16 bits plus the bits covered by the size field) and takes the upper bits from remap-low. A hit in any other window returns the address unchanged.
- R10: A cycle with cpu_valid low gives dec_hit=0, dec_miss=0 and zero target, attribute and address on the next cycle.
- R11: Each lookup produces its result exactly one clock later, so back-to-back lookups give back-to-back results. A register write is seen by lookups presented after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 5 | Register word index (window * 4 + slot) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_word |
| cpu_valid | input | 1 | Lookup request this cycle |
| cpu_addr | input | 32 | CPU physical address to decode |
| dec_hit | output | 1 | Registered: a window claimed the lookup |
| dec_miss | output | 1 | Registered: valid lookup with no window |
| dec_target | output | 4 | Registered target ID of the winning window |
| dec_attr | output | 8 | Registered attribute byte of the winning window |
| dec_addr | output | 32 | Registered translated or passed-through address |

## Verification
Each lookup result is due at the clock edge after the cycle in which cpu_valid and cpu_addr were driven. The bench drives a lookup at a falling edge and queues the expected result. A monitor then compares the outputs shortly after the following rising edge, so every result is matched to exactly one lookup, including idle cycles and back-to-back streams. Register reads have no latency: the bench sets the word index and samples reg_rdata a moment later in the same cycle. Writes are committed one edge before any lookup that depends on them.

// File: rtl/cpu_win_pkg.sv
package cpu_win_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned GRAN_W = 16;
  localparam int unsigned PAGE_W = ADDR_W - GRAN_W;
  localparam int unsigned TGT_W  = 4;
  localparam int unsigned ATTR_W = 8;
  localparam int unsigned EN_POS = 5;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_BASE = 2'd1,
    SLOT_RLO  = 2'd2,
    SLOT_RHI  = 2'd3
  } slot_e;

  typedef struct packed {
    logic [PAGE_W-1:0] size;
    logic [ATTR_W-1:0] attr;
    logic              en;
    logic [TGT_W-1:0]  tgt;
  } win_cfg_t;

  function automatic win_cfg_t unpack_ctrl(input logic [ADDR_W-1:0] word);
    win_cfg_t c;
    c.size = word[ADDR_W-1:GRAN_W];
    c.attr = word[ATTR_W+7:8];
    c.en   = word[EN_POS];
    c.tgt  = word[TGT_W-1:0];
    return c;
  endfunction

  // bits that lie inside the window span
  function automatic logic [ADDR_W-1:0] span_mask(input logic [PAGE_W-1:0] size);
    return {size, {GRAN_W{1'b1}}};
  endfunction

  function automatic logic page_hit(input logic [ADDR_W-1:0] addr,
                                    input logic [PAGE_W-1:0] base_pg,
                                    input logic [PAGE_W-1:0] size);
    logic [ADDR_W-1:0] m;
    m = span_mask(size);
    return ((addr & ~m) == ({base_pg, {GRAN_W{1'b0}}} & ~m));
  endfunction

  function automatic logic [ADDR_W-1:0] xlate(input logic [ADDR_W-1:0] addr,
                                              input logic [PAGE_W-1:0] remap_pg,
                                              input logic [PAGE_W-1:0] size);
    logic [ADDR_W-1:0] m;
    m = span_mask(size);
    return (addr & m) | ({remap_pg, {GRAN_W{1'b0}}} & ~m);
  endfunction

endpackage

// File: rtl/cpu_win_regs.sv
module cpu_win_regs
  import cpu_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 2,
  localparam int unsigned WIN_IDX_W = $clog2(NUM_WIN),
  localparam int unsigned WORD_W    = WIN_IDX_W + 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_we,
  input  logic [WORD_W-1:0]                  reg_word,
  input  logic [ADDR_W-1:0]                  reg_wdata,
  output logic [ADDR_W-1:0]                  reg_rdata,
  output win_cfg_t [NUM_WIN-1:0]             cfg_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]     base_pg_o,
  output logic [NUM_REMAP-1:0][PAGE_W-1:0]   remap_pg_o
);

  logic [WIN_IDX_W-1:0] acc_win;
  slot_e                acc_slot;
  assign acc_win  = reg_word[WORD_W-1:2];
  assign acc_slot = slot_e'(reg_word[1:0]);

  logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl_all, base_all, rlo_all, rhi_all;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              wr_sel;
    logic [ADDR_W-1:0] ctrl_q;
    logic [PAGE_W-1:0] base_q;

    assign wr_sel = reg_we && (acc_win == WIN_IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        base_q <= '0;
      end else if (wr_sel) begin
        if (acc_slot == SLOT_CTRL) ctrl_q <= reg_wdata;
        if (acc_slot == SLOT_BASE) base_q <= reg_wdata[ADDR_W-1:GRAN_W];
      end
    end

    assign ctrl_all[w]  = ctrl_q;
    assign base_all[w]  = {base_q, {GRAN_W{1'b0}}};
    assign cfg_o[w]     = unpack_ctrl(ctrl_q);
    assign base_pg_o[w] = base_q;

    if (w < NUM_REMAP) begin : g_rmp
      logic [PAGE_W-1:0] rlo_q;
      logic [ADDR_W-1:0] rhi_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else if (wr_sel) begin
          if (acc_slot == SLOT_RLO) rlo_q <= reg_wdata[ADDR_W-1:GRAN_W];
          if (acc_slot == SLOT_RHI) rhi_q <= reg_wdata;
        end
      end
      assign rlo_all[w]    = {rlo_q, {GRAN_W{1'b0}}};
      assign rhi_all[w]    = rhi_q;
      assign remap_pg_o[w] = rlo_q;
    end else begin : g_fixed
      assign rlo_all[w] = '0;
      assign rhi_all[w] = '0;
    end
  end

  always_comb begin
    case (acc_slot)
      SLOT_CTRL: reg_rdata = ctrl_all[acc_win];
      SLOT_BASE: reg_rdata = base_all[acc_win];
      SLOT_RLO:  reg_rdata = rlo_all[acc_win];
      SLOT_RHI:  reg_rdata = rhi_all[acc_win];
      default:   reg_rdata = '0;
    endcase
  end

  // remap words of windows without remap hardware read as zero
  p_no_remap_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_slot == SLOT_RLO || acc_slot == SLOT_RHI) && (int'(acc_win) >= NUM_REMAP))
      |-> (reg_rdata == '0));

  // base readback is 64 KB aligned
  p_base_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_slot == SLOT_BASE) |-> (reg_rdata[GRAN_W-1:0] == '0));

  // a zero control write leaves the window disabled
  p_ctrl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && acc_slot == SLOT_CTRL && reg_wdata == '0) |=> !cfg_o[$past(acc_win)].en);

endmodule

// File: rtl/cpu_win_match.sv
module cpu_win_match
  import cpu_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 2
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [NUM_WIN-1:0]                 en_vec,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]     size_vec,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]     base_vec,
  input  logic [NUM_REMAP-1:0][PAGE_W-1:0]   remap_vec,
  output logic [NUM_WIN-1:0]                 hit_vec,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]     xaddr_vec
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w] = en_vec[w] && page_hit(addr, base_vec[w], size_vec[w]);
    if (w < NUM_REMAP) begin : g_xl
      assign xaddr_vec[w] = xlate(addr, remap_vec[w], size_vec[w]);
    end else begin : g_pass
      assign xaddr_vec[w] = addr;
    end
  end

endmodule

// File: rtl/cpu_win_select.sv
module cpu_win_select
  import cpu_win_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_valid,
  input  logic [ADDR_W-1:0]                 cpu_addr,
  input  logic [NUM_WIN-1:0]                hit_vec,
  input  logic [NUM_WIN-1:0][TGT_W-1:0]     tgt_vec,
  input  logic [NUM_WIN-1:0][ATTR_W-1:0]    attr_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    xaddr_vec,
  output logic                              dec_hit,
  output logic                              dec_miss,
  output logic [TGT_W-1:0]                  dec_target,
  output logic [ATTR_W-1:0]                 dec_attr,
  output logic [ADDR_W-1:0]                 dec_addr
);

  logic [NUM_WIN-1:0] grant;
  logic               any_hit;
  logic [TGT_W-1:0]   sel_tgt;
  logic [ATTR_W-1:0]  sel_attr;
  logic [ADDR_W-1:0]  sel_addr;

  // scan from the top so the lowest hitting window is the last to win
  always_comb begin
    grant = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) grant = NUM_WIN'(1) << i;
    end
  end

  assign any_hit = |hit_vec;

  always_comb begin
    sel_tgt  = '0;
    sel_attr = '0;
    sel_addr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) begin
        sel_tgt  = sel_tgt  | tgt_vec[i];
        sel_attr = sel_attr | attr_vec[i];
        sel_addr = sel_addr | xaddr_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_hit    <= 1'b0;
      dec_miss   <= 1'b0;
      dec_target <= '0;
      dec_attr   <= '0;
      dec_addr   <= '0;
    end else begin
      dec_hit    <= cpu_valid && any_hit;
      dec_miss   <= cpu_valid && !any_hit;
      dec_target <= (cpu_valid && any_hit) ? sel_tgt  : '0;
      dec_attr   <= (cpu_valid && any_hit) ? sel_attr : '0;
      dec_addr   <= !cpu_valid ? '0 : (any_hit ? sel_addr : cpu_addr);
    end
  end

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_hit == (grant != '0)));

  p_hit_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && any_hit) |=> dec_hit);

  p_hit_miss_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_hit && dec_miss));

  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> (dec_target == '0 && dec_attr == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |=> (!dec_hit && !dec_miss && dec_addr == '0));

  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> (dec_hit || dec_miss));

endmodule

// File: rtl/cpu_win_decoder.sv
module cpu_win_decoder
  import cpu_win_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 8,
  parameter int unsigned NUM_REMAP = 2,
  localparam int unsigned WORD_W   = $clog2(NUM_WIN) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [WORD_W-1:0]  reg_word,
  input  logic [ADDR_W-1:0]  reg_wdata,
  output logic [ADDR_W-1:0]  reg_rdata,
  input  logic               cpu_valid,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic               dec_hit,
  output logic               dec_miss,
  output logic [TGT_W-1:0]   dec_target,
  output logic [ATTR_W-1:0]  dec_attr,
  output logic [ADDR_W-1:0]  dec_addr
);

  win_cfg_t [NUM_WIN-1:0]             cfg;
  logic [NUM_WIN-1:0][PAGE_W-1:0]     base_pg;
  logic [NUM_REMAP-1:0][PAGE_W-1:0]   remap_pg;
  logic [NUM_WIN-1:0]                 en_vec;
  logic [NUM_WIN-1:0][PAGE_W-1:0]     size_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0]      tgt_vec;
  logic [NUM_WIN-1:0][ATTR_W-1:0]     attr_vec;
  logic [NUM_WIN-1:0]                 hit_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0]     xaddr_vec;

  cpu_win_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_word   (reg_word),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cfg_o      (cfg),
    .base_pg_o  (base_pg),
    .remap_pg_o (remap_pg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_split
    assign en_vec[w]   = cfg[w].en;
    assign size_vec[w] = cfg[w].size;
    assign tgt_vec[w]  = cfg[w].tgt;
    assign attr_vec[w] = cfg[w].attr;
  end

  cpu_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .addr      (cpu_addr),
    .en_vec    (en_vec),
    .size_vec  (size_vec),
    .base_vec  (base_pg),
    .remap_vec (remap_pg),
    .hit_vec   (hit_vec),
    .xaddr_vec (xaddr_vec)
  );

  cpu_win_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_addr   (cpu_addr),
    .hit_vec    (hit_vec),
    .tgt_vec    (tgt_vec),
    .attr_vec   (attr_vec),
    .xaddr_vec  (xaddr_vec),
    .dec_hit    (dec_hit),
    .dec_miss   (dec_miss),
    .dec_target (dec_target),
    .dec_attr   (dec_attr),
    .dec_addr   (dec_addr)
  );

  // a disabled window never produces a hit
  p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~en_vec) == '0);

endmodule

// File: tb/test_cpu_win_decoder.sv
`timescale 1ns/1ps
module test_cpu_win_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        dec_hit, dec_miss;
  logic [3:0]  dec_target;
  logic [7:0]  dec_attr;
  logic [31:0] dec_addr;

  always #2.5 clk = ~clk;

  cpu_win_decoder i_cpu_win_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
    .cpu_addr(cpu_addr), .dec_hit(dec_hit), .dec_miss(dec_miss),
    .dec_target(dec_target), .dec_attr(dec_attr), .dec_addr(dec_addr)
  );

  typedef struct packed {
    logic        hit;
    logic        miss;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] addr;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  logic [31:0] sh_ctrl [8];
  logic [31:0] sh_base [8];
  logic [31:0] sh_rlo  [2];
  logic [31:0] sh_rhi  [2];

  // reference: range form, last hit in descending scan is lowest window
  function automatic res_t model(input logic v, input logic [31:0] a);
    res_t r;
    r = '0;
    if (!v) return r;
    r.miss = 1'b1;
    r.addr = a;
    for (int i = 7; i >= 0; i--) begin
      logic [32:0] start, len;
      start = {1'b0, sh_base[i]};
      len   = ({17'd0, sh_ctrl[i][31:16]} + 33'd1) << 16;
      if (sh_ctrl[i][5] && {1'b0, a} >= start && {1'b0, a} < start + len) begin
        r.hit  = 1'b1;
        r.miss = 1'b0;
        r.tgt  = sh_ctrl[i][3:0];
        r.attr = sh_ctrl[i][15:8];
        if (i < 2) r.addr = 32'((({1'b0, sh_rlo[i]}) & ~(len - 33'd1)) + ({1'b0, a} - start));
        else       r.addr = a;
      end
    end
    return r;
  endfunction

  task automatic wr(input int win, input int slot, input logic [31:0] d);
    @(negedge clk);
    cpu_valid = 1'b0;
    reg_we    = 1'b1;
    reg_word  = 5'(win * 4 + slot);
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (slot)
      0: sh_ctrl[win] = d;
      1: sh_base[win] = d & 32'hFFFF_0000;
      2: if (win < 2) sh_rlo[win] = d & 32'hFFFF_0000;
      default: if (win < 2) sh_rhi[win] = d;
    endcase
  endtask

  task automatic rd_chk(input int win, input int slot, input string req);
    logic [31:0] e;
    @(negedge clk);
    cpu_valid = 1'b0;
    reg_word  = 5'(win * 4 + slot);
    #1;
    case (slot)
      0: e = sh_ctrl[win];
      1: e = sh_base[win];
      2: e = (win < 2) ? sh_rlo[win] : 32'h0;
      default: e = (win < 2) ? sh_rhi[win] : 32'h0;
    endcase
    n_vec++;
    if (reg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: read win %0d slot %0d got %h expected %h", req, win, slot, reg_rdata, e);
    end
  endtask

  // driver: one lookup per falling edge, expectation queued for the monitor
  task automatic look(input logic v, input logic [31:0] a, input string req);
    @(negedge clk);
    cpu_valid = v;
    cpu_addr  = a;
    exp_q.push_back(model(v, a));
    tag_q.push_back(req);
  endtask

  task automatic drain();
    @(negedge clk);
    cpu_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: result of the lookup driven before this rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      res_t e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {dec_hit, dec_miss, dec_target, dec_attr, dec_addr};
      n_vec++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: hit/miss/tgt/attr/addr got %b/%b/%h/%h/%h expected %b/%b/%h/%h/%h",
                 t, g.hit, g.miss, g.tgt, g.attr, g.addr, e.hit, e.miss, e.tgt, e.attr, e.addr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin sh_ctrl[i] = '0; sh_base[i] = '0; end
    for (int i = 0; i < 2; i++) begin sh_rlo[i] = '0; sh_rhi[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if ({dec_hit, dec_miss, dec_target, dec_attr, dec_addr} !== '0) begin
      n_bad++;
      $display("FAIL R1: outputs after reset got %b%b %h %h %h expected all zero",
               dec_hit, dec_miss, dec_target, dec_attr, dec_addr);
    end
    for (int w = 0; w < 8; w++)
      for (int s = 0; s < 4; s++) rd_chk(w, s, "R1");
    look(1'b1, 32'h1234_5678, "R1 R8 miss with all windows off");
    drain();

    // R2 / R5: 64 KB window, target 3, attribute 0x59
    wr(2, 0, 32'h0000_5923);
    wr(2, 1, 32'h9000_1234);
    rd_chk(2, 0, "R2");
    rd_chk(2, 1, "R2");
    look(1'b1, 32'h9000_ABCD, "R5 hit small window");
    look(1'b1, 32'h9001_0000, "R8 just above window");
    look(1'b1, 32'h8FFF_FFFF, "R8 just below window");
    drain();

    // R5: 16 MB window, target 4
    wr(3, 0, 32'h00FF_5924);
    wr(3, 1, 32'hA000_0000);
    look(1'b1, 32'hA000_0000, "R5 first byte");
    look(1'b1, 32'hA0FF_FFFF, "R5 last byte");
    look(1'b1, 32'hA100_0000, "R8 past end");
    drain();

    // R3 / R9: remapped 1 MB window 0
    wr(0, 0, 32'h000F_0F21);
    wr(0, 1, 32'hF800_0000);
    wr(0, 2, 32'h1234_5678);
    wr(0, 3, 32'hDEAD_BEEF);
    rd_chk(0, 2, "R3");
    rd_chk(0, 3, "R3");
    look(1'b1, 32'hF80A_BCDE, "R9 remap 1 MB window");
    look(1'b1, 32'hF800_0000, "R9 remap first byte");
    drain();

    // R4: remap words of window 2 are absent
    wr(2, 2, 32'h5555_0000);
    wr(2, 3, 32'hFFFF_FFFF);
    rd_chk(2, 2, "R4");
    rd_chk(2, 3, "R4");
    look(1'b1, 32'h9000_0042, "R4 R9 no translation in window 2");
    drain();

    // R7: overlapping windows
    wr(5, 0, 32'h0000_1E27);
    wr(5, 1, 32'h9000_0000);
    look(1'b1, 32'h9000_0100, "R7 window 2 beats window 5");
    wr(1, 0, 32'h0000_0F21);
    wr(1, 1, 32'hA050_0000);
    wr(1, 2, 32'h0003_0000);
    look(1'b1, 32'hA050_1234, "R7 R9 window 1 beats window 3");
    look(1'b1, 32'hA051_0000, "R7 window 3 outside window 1");
    drain();

    // R6: disable paths
    wr(2, 0, 32'h0);
    rd_chk(2, 0, "R6");
    look(1'b1, 32'h9000_0100, "R6 window 5 after window 2 cleared");
    wr(5, 0, 32'h0000_1E07);
    look(1'b1, 32'h9000_0100, "R6 enable bit low");
    drain();

    // R10 / R11: idle cycles and back-to-back stream
    look(1'b0, 32'hA000_0000, "R10 idle");
    look(1'b1, 32'hA000_0010, "R11 stream");
    look(1'b1, 32'hF800_0004, "R11 stream");
    look(1'b0, 32'hF800_0004, "R10 idle in stream");
    look(1'b1, 32'h0000_0000, "R11 stream miss");
    look(1'b1, 32'hA050_FFFF, "R11 stream remap");
    drain();

    // R11: a write is seen by the next lookup
    wr(7, 0, 32'h0000_0F21);
    wr(7, 1, 32'h0000_0000);
    look(1'b1, 32'h0000_8000, "R11 after write");
    drain();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule